// File: doc/BRIEF.md
# Hall-Sensor Commutation Decoder

This block sits between the three Hall position sensors of a brushless three-phase motor and the six gate enables of its inverter bridge. It resynchronises the raw sensor lines, accepts a new position code only once it has held steady for a programmable number of clocks, and looks up which high-side and which low-side switch to close for that rotor position. Sensor spacing of 120 or 60 electrical degrees and forward or reverse rotation are selected by input pins. Codes that cannot occur for the chosen spacing are reported as a fault and open the bridge.

Two electrical braking methods are offered. Counter-torque braking applies the drive pattern of the opposite rotation, so the motor is pushed against its present motion. Winding-short braking closes all three low-side switches, so the windings form a closed loop. The outputs are plain on/off enables: a downstream modulator chops them, adds its own dead band and sets speed. Each switch is turned on only after its partner on the same phase was already off in the previous cycle, so the outputs never overlap even when direction, mode or brake change at once.

The sensor code is written A:B:C, with `hall_in[2]` = A, `hall_in[1]` = B and `hall_in[0]` = C. Output bit 0 is phase A, bit 1 phase B, bit 2 phase C.

Top module: `hall_commutator`

## Requirements
- R1: With 120-degree spacing and forward drive, the accepted code selects (high, low): 101 A/B, 001 C/B, 011 C/A, 010 B/A, 110 B/C, 100 A/C; no other enable is on.
- R2: Reverse drive (`dir_rev`=1) swaps the high and low phases of the forward pattern for every valid code.
- R3: With 60-degree spacing (`sensor_60`=1) the mapping is 000 A/B, 001 C/B, 011 C/A, 111 B/A, 110 B/C, 100 A/C; codes 010 and 101 are invalid.
- R4: An invalid accepted code (000 or 111 at 120 degrees, 010 or 101 at 60 degrees) sets `hall_fault` and switches every high-side enable off, and every low-side enable off unless winding-short braking is active; `hall_fault` clears when a valid code is accepted.
- R5: In any valid drive state exactly one high-side and exactly one low-side enable are on, on different phases.
- R6: The high-side and low-side enable of one phase are never on together, and a switch is turned on only if its partner on the same phase was off in the previous cycle.
- R7: A sensor code held for fewer than `filt_len` clocks is ignored; a code held steadily is accepted no earlier than `filt_len`+1 and no later than `filt_len`+8 clocks after it appears at the pins.
- R8: `comm_strobe` pulses for exactly one cycle each time a code is accepted and is otherwise low.
- R9: With `brake_req`=1 and `brake_short`=0 the outputs carry the pattern of the direction opposite to `dir_rev`, whether or not `run_en` is set.
- R10: With `brake_req`=1 and `brake_short`=1 all three low-side enables are on and all high-side enables are off, for any sensor code.
- R11: With `run_en`=0 and `brake_req`=0 all six enables are off.
- R12: During and right after reset all enables, `comm_strobe` and `hall_fault` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hall_in | input | 3 | Raw sensor lines, bit 2 = A, bit 1 = B, bit 0 = C |
| filt_len | input | FILT_W | Stability length in clocks before a code change is taken |
| run_en | input | 1 | Enables motoring drive |
| dir_rev | input | 1 | 0 = forward rotation, 1 = reverse |
| sensor_60 | input | 1 | 0 = 120-degree spacing, 1 = 60-degree spacing |
| brake_req | input | 1 | Requests electrical braking, overrides run_en |
| brake_short | input | 1 | Brake method: 0 = counter-torque, 1 = low-side short |
| hs_en | output | 3 | High-side enables, bit 0 = A |
| ls_en | output | 3 | Low-side enables, bit 0 = A |
| comm_strobe | output | 1 | One-cycle pulse on each accepted code |
| hall_fault | output | 1 | Accepted code is invalid for the spacing |

## Verification
The assertions take for granted that reset is held for at least one clock so that every history register starts from zero, and that `filt_len` is not changed while a code is being qualified. The stimulus sets `filt_len` once before reset is released, changes the mode and brake pins only on the falling clock edge, and holds each sensor code for well beyond the filter window except in the deliberate short-glitch case. The bench sweeps all eight codes under every spacing and direction pair so that mode flips with the code unchanged exercise the same-phase turn-on gap.

// File: rtl/hall_comm_pkg.sv
// Package: shared constants and the drive pattern type of the commutation decoder.
// Assumes three phases; bit 0 of every phase vector is phase A.
package hall_comm_pkg;
    localparam int NUM_PH = 3;

    localparam logic [NUM_PH-1:0] PH_A = 3'b001;
    localparam logic [NUM_PH-1:0] PH_B = 3'b010;
    localparam logic [NUM_PH-1:0] PH_C = 3'b100;

    // One bridge pattern: which high and low switches close, and whether the code was invalid.
    typedef struct packed {
        logic              bad;
        logic [NUM_PH-1:0] hs;
        logic [NUM_PH-1:0] ls;
    } drive_pat_t;
endpackage

// File: rtl/hall_sync_filter.sv
// Module: two-flop synchroniser plus stability qualifier for the sensor code.
// A sampled code must equal the previous sample and differ from the accepted
// code for more than filt_len clocks before it becomes the accepted code.
// Assumes filt_len is held constant while a code is being qualified.
module hall_sync_filter #(
    parameter int CODE_W = 3,
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] raw,
    input  logic [FILT_W-1:0] filt_len,
    output logic [CODE_W-1:0] code,
    output logic              code_valid,
    output logic              accept
);
    localparam logic [FILT_W-1:0] CNT_MAX = '1;

    logic [CODE_W-1:0] meta_q;
    logic [CODE_W-1:0] sync_q;
    logic [CODE_W-1:0] last_q;
    logic [FILT_W-1:0] cnt_q;
    logic              differs;
    logic              steady;
    logic              take;

    assign differs = (sync_q != code) || !code_valid;
    assign steady  = (sync_q == last_q);
    assign take    = differs && steady && (cnt_q >= filt_len);

    // Purpose: bring the raw lines into the clock domain and keep one older sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
            last_q <= '0;
        end else begin
            meta_q <= raw;
            sync_q <= meta_q;
            last_q <= sync_q;
        end
    end

    // Purpose: count consecutive steady samples of a new code, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take || !differs || !steady) begin
            cnt_q <= '0;
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Purpose: latch the qualified code and issue the one-cycle accept pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code       <= '0;
            code_valid <= 1'b0;
            accept     <= 1'b0;
        end else begin
            accept <= take;
            if (take) begin
                code       <= sync_q;
                code_valid <= 1'b1;
            end
        end
    end

    // R7: an accepted code was seen steady on the two most recent samples.
    assert_accept_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> (code == $past(sync_q) && $past(sync_q) == $past(last_q)));

    // R8: the accept pulse never lasts two cycles.
    assert_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
endmodule

// File: rtl/commute_lut.sv
// Module: combinational decode of an accepted sensor code into a switch pair.
// 60-degree codes are first folded onto the 120-degree code of the same rotor
// sector; reverse drive swaps the high and low phases. Invalid codes give bad=1
// and no switch.
module commute_lut
    import hall_comm_pkg::*;
(
    input  logic [2:0] code,
    input  logic       sixty,
    input  logic       reverse,
    output drive_pat_t pat
);
    logic [2:0]        norm;
    logic              bad;
    logic [NUM_PH-1:0] hi_ph;
    logic [NUM_PH-1:0] lo_ph;

    // Purpose: fold the spacing variant onto one sector numbering and flag impossible codes.
    always_comb begin
        norm = code;
        bad  = 1'b0;
        if (sixty) begin
            case (code)
                3'b000:         norm = 3'b101;
                3'b111:         norm = 3'b010;
                3'b010, 3'b101: bad  = 1'b1;
                default:        norm = code;
            endcase
        end else begin
            bad = (code == 3'b000) || (code == 3'b111);
        end
    end

    // Purpose: forward-rotation switch pair for each sector.
    always_comb begin
        case (norm)
            3'b101:  begin hi_ph = PH_A; lo_ph = PH_B; end
            3'b001:  begin hi_ph = PH_C; lo_ph = PH_B; end
            3'b011:  begin hi_ph = PH_C; lo_ph = PH_A; end
            3'b010:  begin hi_ph = PH_B; lo_ph = PH_A; end
            3'b110:  begin hi_ph = PH_B; lo_ph = PH_C; end
            3'b100:  begin hi_ph = PH_A; lo_ph = PH_C; end
            default: begin hi_ph = '0;   lo_ph = '0;   end
        endcase
    end

    // Purpose: apply direction and suppress the pair for invalid codes.
    always_comb begin
        pat.bad = bad;
        if (bad) begin
            pat.hs = '0;
            pat.ls = '0;
        end else if (reverse) begin
            pat.hs = lo_ph;
            pat.ls = hi_ph;
        end else begin
            pat.hs = hi_ph;
            pat.ls = lo_ph;
        end
    end
endmodule

// File: rtl/hall_drive_stage.sv
// Module: registered bridge output stage with braking and same-phase interlock.
// A switch closes only if its partner on the same phase was open in the
// previous cycle, so a swap of high and low on one phase passes through a
// cycle with both open. Assumes reset is held for at least one clock.
module hall_drive_stage
    import hall_comm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  drive_pat_t        pat,
    input  logic              code_valid,
    input  logic              run_en,
    input  logic              brake_req,
    input  logic              brake_short,
    output logic [NUM_PH-1:0] hs_en,
    output logic [NUM_PH-1:0] ls_en,
    output logic              fault
);
    logic [NUM_PH-1:0] want_hs;
    logic [NUM_PH-1:0] want_ls;

    // Purpose: choose the requested bridge state from brake, run and pattern.
    always_comb begin
        want_hs = '0;
        want_ls = '0;
        if (brake_req && brake_short) begin
            want_ls = '1;
        end else if ((brake_req || run_en) && code_valid && !pat.bad) begin
            want_hs = pat.hs;
            want_ls = pat.ls;
        end
    end

    generate
        for (genvar p = 0; p < NUM_PH; p++) begin : g_leg
            logic hs_q;
            logic ls_q;

            // Purpose: per-leg register that closes a switch only after its partner was open.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hs_q <= 1'b0;
                    ls_q <= 1'b0;
                end else begin
                    hs_q <= want_hs[p] & ~ls_q;
                    ls_q <= want_ls[p] & ~hs_q;
                end
            end

            assign hs_en[p] = hs_q;
            assign ls_en[p] = ls_q;
        end
    endgenerate

    // Purpose: register the invalid-code flag alongside the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fault <= 1'b0;
        end else begin
            fault <= code_valid && pat.bad;
        end
    end

    // R6: no leg ever has both switches closed.
    assert_no_shoot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_en & ls_en) == '0);

    // R6: a switch that just closed had an open partner one cycle earlier.
    assert_turn_on_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((ls_en & ~$past(ls_en) & $past(hs_en)) | (hs_en & ~$past(hs_en) & $past(ls_en))) == '0);

    // R5: at most one high-side switch at any time.
    assert_one_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hs_en));

    // R5: outside a short brake and its release cycle, at most one low-side switch.
    assert_one_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!brake_req && !$past(brake_req)) |-> $onehot0(ls_en));

    // R4: an invalid code never leaves a high-side switch closed.
    assert_fault_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (hs_en == '0));
endmodule

// File: rtl/hall_commutator.sv
// Module: top of the Hall-sensor commutation decoder.
// Chains the synchroniser/qualifier, the sector table and the output stage.
// Counter-torque braking is realised by flipping the direction fed to the table.
module hall_commutator
    import hall_comm_pkg::*;
#(
    parameter int FILT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        hall_in,
    input  logic [FILT_W-1:0] filt_len,
    input  logic              run_en,
    input  logic              dir_rev,
    input  logic              sensor_60,
    input  logic              brake_req,
    input  logic              brake_short,
    output logic [2:0]        hs_en,
    output logic [2:0]        ls_en,
    output logic              comm_strobe,
    output logic              hall_fault
);
    logic [2:0] acc_code;
    logic       acc_valid;
    logic       eff_rev;
    drive_pat_t pat;

    assign eff_rev = dir_rev ^ (brake_req && !brake_short);

    hall_sync_filter #(
        .CODE_W (3),
        .FILT_W (FILT_W)
    ) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw        (hall_in),
        .filt_len   (filt_len),
        .code       (acc_code),
        .code_valid (acc_valid),
        .accept     (comm_strobe)
    );

    commute_lut u_lut (
        .code    (acc_code),
        .sixty   (sensor_60),
        .reverse (eff_rev),
        .pat     (pat)
    );

    hall_drive_stage u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .pat         (pat),
        .code_valid  (acc_valid),
        .run_en      (run_en),
        .brake_req   (brake_req),
        .brake_short (brake_short),
        .hs_en       (hs_en),
        .ls_en       (ls_en),
        .fault       (hall_fault)
    );

    // R10: two cycles of short braking leave every low-side switch closed.
    assert_short_brake_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(brake_req && brake_short) && brake_req && brake_short && $past(hs_en) == '0)
            |=> (ls_en == 3'b111));
endmodule

// File: tb/test_hall_commutator.sv
// Bench: sweeps every code under every spacing and direction, then the filter,
// strobe, brake and idle cases. Expected pairs are derived from the odd bit of
// the code: the phase whose bit differs from the other two.
module test_hall_commutator;
    localparam int CLK_PERIOD = 10;
    localparam int FILT_W     = 8;
    localparam int FILT       = 4;
    localparam int SETTLE     = FILT + 12;

    logic              clk = 1'b0;
    logic              rst_n;
    logic [2:0]        hall_in;
    logic [FILT_W-1:0] filt_len;
    logic              run_en, dir_rev, sensor_60, brake_req, brake_short;
    logic [2:0]        hs_en, ls_en;
    logic              comm_strobe, hall_fault;

    int checks = 0;
    int errors = 0;
    int strobes = 0;
    int overlap_err = 0;
    int gap_err = 0;
    logic [2:0] prev_hs = '0;
    logic [2:0] prev_ls = '0;

    hall_commutator #(.FILT_W(FILT_W)) i_hall_commutator (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .filt_len(filt_len),
        .run_en(run_en), .dir_rev(dir_rev), .sensor_60(sensor_60),
        .brake_req(brake_req), .brake_short(brake_short),
        .hs_en(hs_en), .ls_en(ls_en), .comm_strobe(comm_strobe), .hall_fault(hall_fault)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Observation away from the active edge: strobes, overlap and turn-on gap.
    always @(negedge clk) begin
        if (rst_n) begin
            if (comm_strobe) strobes++;
            if ((hs_en & ls_en) != 0) overlap_err++;
            if (((ls_en & ~prev_ls & prev_hs) | (hs_en & ~prev_hs & prev_ls)) != 0) gap_err++;
        end
        prev_hs = hs_en;
        prev_ls = ls_en;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Returns {bad, hs[2:0], ls[2:0]}.
    function automatic logic [6:0] expect_pat(input logic [2:0] c, input logic s60, input logic rev);
        logic [2:0] n;
        int odd, other, hi, lo, tmp;
        n = c;
        if (s60) begin
            if (c == 3'b000) n = 3'b101;
            else if (c == 3'b111) n = 3'b010;
            else if (c == 3'b010 || c == 3'b101) return 7'b1000000;
        end else if (c == 3'b000 || c == 3'b111) begin
            return 7'b1000000;
        end
        if (n[2] != n[1] && n[2] != n[0]) odd = 0;
        else if (n[1] != n[2] && n[1] != n[0]) odd = 1;
        else odd = 2;
        other = (odd + 2) % 3;
        if (n[2-odd]) begin hi = odd; lo = other; end
        else begin lo = odd; hi = other; end
        if (rev) begin tmp = hi; hi = lo; lo = tmp; end
        return {1'b0, 3'(1 << hi), 3'(1 << lo)};
    endfunction

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [6:0] e;
        logic [2:0] prev_code;
        int s0;
        string tag;
        rst_n = 1'b0; hall_in = 3'b001; filt_len = FILT;
        run_en = 1'b1; dir_rev = 1'b0; sensor_60 = 1'b0;
        brake_req = 1'b0; brake_short = 1'b0;
        wait_cycles(4);
        // R12: reset state
        check(hs_en == 0 && ls_en == 0, "R12 enables", {hs_en, ls_en}, 0);
        check(!comm_strobe && !hall_fault, "R12 flags", {comm_strobe, hall_fault}, 0);
        @(negedge clk) rst_n = 1'b1;
        check(hs_en == 0 && ls_en == 0 && !hall_fault, "R12 after release", {hs_en, ls_en, hall_fault}, 0);
        wait_cycles(SETTLE);
        prev_code = 3'b001;

        // R1 R2 R3 R4 R5 R8: full sweep
        for (int m = 0; m < 4; m++) begin
            for (int c = 0; c < 8; c++) begin
                sensor_60 = m[1]; dir_rev = m[0]; hall_in = 3'(c);
                s0 = strobes;
                wait_cycles(SETTLE);
                e = expect_pat(3'(c), m[1], m[0]);
                if (e[6]) tag = "R4";
                else if (m[1]) tag = "R3";
                else if (m[0]) tag = "R2";
                else tag = "R1";
                check({hall_fault, hs_en, ls_en} == e, tag, {hall_fault, hs_en, ls_en}, e);
                if (!e[6]) check($countones(hs_en) == 1 && $countones(ls_en) == 1 && (hs_en & ls_en) == 0,
                                 "R5 one pair", {hs_en, ls_en}, e[5:0]);
                check(strobes - s0 == ((3'(c) != prev_code) ? 1 : 0), "R8 strobe count",
                      strobes - s0, (3'(c) != prev_code) ? 1 : 0);
                prev_code = 3'(c);
            end
        end

        // R7: acceptance latency window
        sensor_60 = 1'b0; dir_rev = 1'b0; hall_in = 3'b001;
        wait_cycles(SETTLE);
        begin
            int lat;
            lat = 0;
            hall_in = 3'b100;
            for (int k = 1; k <= 40; k++) begin
                @(negedge clk);
                if (comm_strobe && lat == 0) lat = k;
            end
            check(lat >= FILT + 1 && lat <= FILT + 8, "R7 latency", lat, FILT + 4);
        end

        // R7: short glitch ignored
        s0 = strobes;
        hall_in = 3'b110;
        wait_cycles(FILT - 1);
        hall_in = 3'b100;
        wait_cycles(SETTLE);
        check(strobes == s0, "R7 glitch strobe", strobes - s0, 0);
        e = expect_pat(3'b100, 1'b0, 1'b0);
        check({hall_fault, hs_en, ls_en} == e, "R7 glitch outputs", {hall_fault, hs_en, ls_en}, e);

        // R9: counter-torque brake, with and without run enable
        brake_req = 1'b1; brake_short = 1'b0;
        wait_cycles(6);
        e = expect_pat(3'b100, 1'b0, 1'b1);
        check({hall_fault, hs_en, ls_en} == e, "R9 brake fwd", {hall_fault, hs_en, ls_en}, e);
        run_en = 1'b0; dir_rev = 1'b1;
        wait_cycles(6);
        e = expect_pat(3'b100, 1'b0, 1'b0);
        check({hall_fault, hs_en, ls_en} == e, "R9 brake rev no run", {hall_fault, hs_en, ls_en}, e);

        // R10: short brake, valid and invalid code
        brake_short = 1'b1;
        wait_cycles(6);
        check(hs_en == 0 && ls_en == 3'b111, "R10 short", {hs_en, ls_en}, 6'b000111);
        hall_in = 3'b111;
        wait_cycles(SETTLE);
        check(hs_en == 0 && ls_en == 3'b111 && hall_fault, "R10 short invalid",
              {hall_fault, hs_en, ls_en}, 7'b1000111);

        // R11: idle opens the bridge
        hall_in = 3'b011;
        brake_req = 1'b0; brake_short = 1'b0; run_en = 1'b0;
        wait_cycles(SETTLE);
        check(hs_en == 0 && ls_en == 0 && !hall_fault, "R11 idle", {hall_fault, hs_en, ls_en}, 0);
        run_en = 1'b1; dir_rev = 1'b0;
        wait_cycles(6);
        e = expect_pat(3'b011, 1'b0, 1'b0);
        check({hall_fault, hs_en, ls_en} == e, "R11 resume", {hall_fault, hs_en, ls_en}, e);

        // R6: interlock over the whole run
        check(overlap_err == 0, "R6 overlap", overlap_err, 0);
        check(gap_err == 0, "R6 turn-on gap", gap_err, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule